// File: doc/BRIEF.md
# Thresholded Transmit/Receive Data Queue

This block is a first-in first-out data queue built on a 256-byte storage array. A serial port instantiates it twice, once for outgoing and once for incoming data. Software chooses the entry width as byte, halfword or word. Each push writes one entry of that width and each pop removes one. Multi-byte entries are laid out in storage with the least significant byte first. The queue keeps its fill level as a count of entries of the selected width.

An operation strobe empties, starts or stops the queue. Pushes and pops are accepted only while the queue is started. A status word reports the level and the full and empty conditions. The queue also compares its fill against two kinds of programmable marks. The first is an 8-bit threshold held in the control word, which drives a flag for the interrupt logic. The second is a set of three 6-bit marks in a level-check word, each compared against the fill counted in 4-byte units. The bus interface and the shift engine sit outside this block.

Top module: `tdq_queue`

## Requirements
- R1: `cfg_ctrl[1:0]` selects the entry width: 0 is a byte, 1 a halfword, and 2 or 3 a 32-bit word. A pushed entry occupies consecutive bytes, least significant byte first. `pop_data` shows the oldest entry, zero-extended to 32 bits.
- R2: The storage holds 256 bytes. The queue therefore holds at most 256 byte entries, 128 halfword entries or 64 word entries.
- R3: `status[7:0]` is the number of stored entries modulo 256, `status[8]` is full and `status[9]` is empty. Full means no room remains for one more entry of the selected width. Full and empty are never both set.
- R4: A push while the queue is full is ignored. It changes neither the level nor the stored data.
- R5: A pop while the queue is empty is ignored, and the level stays at zero.
- R6: An operation write (`op_wr`) with `op_val[0]` set empties the queue. `op_val` equal to 2 starts the queue. `op_val` equal to 0 stops it and keeps its contents. In the cycle of an operation write, any push or pop is ignored.
- R7: While the queue is stopped, pushes and pops have no effect, and the oldest entry stays visible on `pop_data`.
- R8: If `op_val` is 3, the reset takes priority. The queue is emptied and left stopped.
- R9: Entries are popped in the order they were pushed, with their values intact.
- R10: `thr_hit` is high exactly when the entry count is greater than or equal to the threshold `cfg_ctrl[9:2]`.
- R11: `lvl_chk` holds three 6-bit marks at bits 5:0, 15:10 and 25:20. `mark_hit[k]` is high when the stored byte count divided by 4 (rounded down) is greater than or equal to mark k.
- R12: A push and a pop in the same cycle, on a queue that is neither full nor empty, are both accepted. The level is unchanged afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ctrl | input | 10 | Entry width [1:0], threshold [9:2] |
| op_wr | input | 1 | Operation write strobe |
| op_val | input | 2 | Operation value: bit 0 empties, bit 1 starts |
| lvl_chk | input | 26 | Three 6-bit level-check marks |
| push_en | input | 1 | Push one entry |
| push_data | input | 32 | Entry to push, low bytes used |
| pop_en | input | 1 | Pop the oldest entry |
| pop_data | output | 32 | Oldest entry, zero-extended |
| status | output | 10 | Level, full and empty |
| thr_hit | output | 1 | Threshold reached |
| mark_hit | output | 3 | Level-check mark comparisons |

## Verification
The checker watches several invariants on every cycle: a push into a full queue or a pop from an empty one leaves the byte count unchanged, a stopped queue does not move, full and empty are never asserted together, the count never exceeds the storage, and a reset write empties the queue and leaves it stopped. Other behaviour only shows up under scenarios in the bench. This covers the byte order within wide entries, the end-to-end order and values of data, the exact capacity at each width, the threshold and mark crossings as the queue fills, and a simultaneous push and pop. The bench sweeps every width from empty to beyond full and back again, computing each expected value arithmetically.

// File: rtl/tdq_pkg.sv
package tdq_pkg;

   typedef enum logic [1:0] {
      EW_BYTE = 2'd0,
      EW_HALF = 2'd1,
      EW_WORD = 2'd2,
      EW_WIDE = 2'd3
   } ent_w_e;

   function automatic logic [2:0] ent_bytes(input ent_w_e w);
      case (w)
         EW_BYTE: ent_bytes = 3'd1;
         EW_HALF: ent_bytes = 3'd2;
         default: ent_bytes = 3'd4;
      endcase
   endfunction

   function automatic logic [1:0] ent_shift(input ent_w_e w);
      case (w)
         EW_BYTE: ent_shift = 2'd0;
         EW_HALF: ent_shift = 2'd1;
         default: ent_shift = 2'd2;
      endcase
   endfunction

endpackage

// File: rtl/tdq_gate.sv
module tdq_gate (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       op_wr,
   input  logic [1:0] op_val,
   input  logic       push_en,
   input  logic       pop_en,
   input  logic       room_ok,
   input  logic       data_ok,
   output logic       run,
   output logic       flush,
   output logic       push_ok,
   output logic       pop_ok
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
      end else if (op_wr) begin
         if (op_val[0]) run <= 1'b0;
         else           run <= op_val[1];
      end
   end

   assign flush   = op_wr & op_val[0];
   assign push_ok = run & ~op_wr & push_en & room_ok;
   assign pop_ok  = run & ~op_wr & pop_en & data_ok;

endmodule

// File: rtl/tdq_store.sv
module tdq_store #(
   parameter int DEPTH  = 256,
   parameter int DATA_W = 32,
   localparam int AW    = $clog2(DEPTH),
   localparam int LANES = DATA_W / 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_ptr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_ptr,
   input  logic [2:0]        nbytes,
   output logic [DATA_W-1:0] rd_data
);

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int i = 0; i < LANES; i++) begin
            if (3'(i) < nbytes)
               mem[wr_ptr + AW'(i)] <= wr_data[8*i +: 8];
         end
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign rd_data[8*g +: 8] = (3'(g) < nbytes) ? mem[rd_ptr + AW'(g)] : 8'h00;
   end

endmodule

// File: rtl/tdq_level.sv
module tdq_level #(
   parameter int DEPTH       = 256,
   parameter int THR_W       = 8,
   parameter int MARK_W      = 6,
   parameter int N_MARKS     = 3,
   parameter int MARK_STRIDE = 10,
   localparam int AW         = $clog2(DEPTH),
   localparam int LVL_W      = AW + 1,
   localparam int CHK_W      = (N_MARKS - 1) * MARK_STRIDE + MARK_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               push_ok,
   input  logic               pop_ok,
   input  logic [2:0]         nbytes,
   input  logic [1:0]         shift,
   input  logic [THR_W-1:0]   thresh,
   input  logic [CHK_W-1:0]   lvl_chk,
   output logic [LVL_W-1:0]   byte_cnt,
   output logic [AW-1:0]      wr_ptr,
   output logic [AW-1:0]      rd_ptr,
   output logic               room_ok,
   output logic               data_ok,
   output logic [AW+1:0]      status,
   output logic               thr_hit,
   output logic [N_MARKS-1:0] mark_hit
);

   localparam logic [LVL_W-1:0] CAP = LVL_W'(DEPTH);

   logic [LVL_W-1:0] nb_ext;
   logic [LVL_W-1:0] entries;
   logic [LVL_W-1:0] units;
   logic [LVL_W-1:0] cnt_nxt;

   assign nb_ext  = LVL_W'(nbytes);
   assign room_ok = (byte_cnt + nb_ext) <= CAP;
   assign data_ok = byte_cnt >= nb_ext;
   assign entries = byte_cnt >> shift;
   assign units   = byte_cnt >> 2;

   always_comb begin
      cnt_nxt = byte_cnt;
      if (push_ok) cnt_nxt = cnt_nxt + nb_ext;
      if (pop_ok)  cnt_nxt = cnt_nxt - nb_ext;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_cnt <= '0;
         wr_ptr   <= '0;
         rd_ptr   <= '0;
      end else if (flush) begin
         byte_cnt <= '0;
         wr_ptr   <= '0;
         rd_ptr   <= '0;
      end else begin
         byte_cnt <= cnt_nxt;
         if (push_ok) wr_ptr <= wr_ptr + AW'(nbytes);
         if (pop_ok)  rd_ptr <= rd_ptr + AW'(nbytes);
      end
   end

   assign status = {~data_ok, ~room_ok, entries[AW-1:0]};

   if (THR_W >= LVL_W) begin : g_thr_wide
      assign thr_hit = THR_W'(entries) >= thresh;
   end else begin : g_thr_narrow
      assign thr_hit = entries >= LVL_W'(thresh);
   end

   for (genvar k = 0; k < N_MARKS; k++) begin : g_mark
      logic [MARK_W-1:0] mark;
      assign mark = lvl_chk[k*MARK_STRIDE +: MARK_W];
      if (MARK_W >= LVL_W) begin : g_wide
         assign mark_hit[k] = MARK_W'(units) >= mark;
      end else begin : g_narrow
         assign mark_hit[k] = units >= LVL_W'(mark);
      end
   end

endmodule

// File: rtl/tdq_queue.sv
module tdq_queue #(
   parameter int DEPTH       = 256,
   parameter int DATA_W      = 32,
   parameter int THR_W       = 8,
   parameter int MARK_W      = 6,
   parameter int N_MARKS     = 3,
   parameter int MARK_STRIDE = 10,
   localparam int AW         = $clog2(DEPTH),
   localparam int LVL_W      = AW + 1,
   localparam int CTRL_W     = 2 + THR_W,
   localparam int CHK_W      = (N_MARKS - 1) * MARK_STRIDE + MARK_W,
   localparam int STAT_W     = AW + 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CTRL_W-1:0]  cfg_ctrl,
   input  logic               op_wr,
   input  logic [1:0]         op_val,
   input  logic [CHK_W-1:0]   lvl_chk,
   input  logic               push_en,
   input  logic [DATA_W-1:0]  push_data,
   input  logic               pop_en,
   output logic [DATA_W-1:0]  pop_data,
   output logic [STAT_W-1:0]  status,
   output logic               thr_hit,
   output logic [N_MARKS-1:0] mark_hit
);
   import tdq_pkg::*;

   if (DATA_W != 32) begin : g_bad_width
      $error("tdq_queue: DATA_W must be 32 to hold a word entry");
   end
   if (DEPTH < 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("tdq_queue: DEPTH must be a power of two of at least 8");
   end
   if (MARK_STRIDE < MARK_W) begin : g_bad_stride
      $error("tdq_queue: mark fields overlap");
   end

   ent_w_e           ew;
   logic [2:0]       nbytes;
   logic [1:0]       shift;
   logic             run;
   logic             flush;
   logic             push_ok;
   logic             pop_ok;
   logic             room_ok;
   logic             data_ok;
   logic [LVL_W-1:0] byte_cnt;
   logic [AW-1:0]    wr_ptr;
   logic [AW-1:0]    rd_ptr;

   assign ew     = ent_w_e'(cfg_ctrl[1:0]);
   assign nbytes = ent_bytes(ew);
   assign shift  = ent_shift(ew);

   tdq_gate u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_wr   (op_wr),
      .op_val  (op_val),
      .push_en (push_en),
      .pop_en  (pop_en),
      .room_ok (room_ok),
      .data_ok (data_ok),
      .run     (run),
      .flush   (flush),
      .push_ok (push_ok),
      .pop_ok  (pop_ok)
   );

   tdq_level #(
      .DEPTH       (DEPTH),
      .THR_W       (THR_W),
      .MARK_W      (MARK_W),
      .N_MARKS     (N_MARKS),
      .MARK_STRIDE (MARK_STRIDE)
   ) u_level (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .push_ok  (push_ok),
      .pop_ok   (pop_ok),
      .nbytes   (nbytes),
      .shift    (shift),
      .thresh   (cfg_ctrl[CTRL_W-1:2]),
      .lvl_chk  (lvl_chk),
      .byte_cnt (byte_cnt),
      .wr_ptr   (wr_ptr),
      .rd_ptr   (rd_ptr),
      .room_ok  (room_ok),
      .data_ok  (data_ok),
      .status   (status),
      .thr_hit  (thr_hit),
      .mark_hit (mark_hit)
   );

   tdq_store #(
      .DEPTH  (DEPTH),
      .DATA_W (DATA_W)
   ) u_store (
      .clk     (clk),
      .wr_en   (push_ok),
      .wr_ptr  (wr_ptr),
      .wr_data (push_data),
      .rd_ptr  (rd_ptr),
      .nbytes  (nbytes),
      .rd_data (pop_data)
   );

endmodule

// File: rtl/tdq_queue_chk.sv
module tdq_queue_chk #(
   parameter int DEPTH  = 256,
   parameter int LVL_W  = 9,
   parameter int STAT_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_wr,
   input logic [1:0]        op_val,
   input logic              push_en,
   input logic              pop_en,
   input logic              run,
   input logic [LVL_W-1:0]  byte_cnt,
   input logic [STAT_W-1:0] status
);
   localparam int FULL_B  = STAT_W - 2;
   localparam int EMPTY_B = STAT_W - 1;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      status[FULL_B] && push_en && !pop_en && !op_wr |=> $stable(byte_cnt)); // R4

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      status[EMPTY_B] && pop_en && !push_en && !op_wr |=> $stable(byte_cnt)); // R5

   AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !run && !op_wr |=> $stable(byte_cnt)); // R7

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      op_wr && op_val[0] |=> byte_cnt == '0); // R6

   AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      op_wr && op_val == 2'b11 |=> !run && status[EMPTY_B]); // R8

   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(status[FULL_B] && status[EMPTY_B])); // R3

   AST_CAPACITY: assert property (@(posedge clk) disable iff (!rst_n)
      byte_cnt <= LVL_W'(DEPTH)); // R2

endmodule

bind tdq_queue tdq_queue_chk #(
   .DEPTH  (DEPTH),
   .LVL_W  (LVL_W),
   .STAT_W (STAT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_wr    (op_wr),
   .op_val   (op_val),
   .push_en  (push_en),
   .pop_en   (pop_en),
   .run      (run),
   .byte_cnt (byte_cnt),
   .status   (status)
);

// File: tb/tdq_queue_test.sv
`timescale 1ns/1ps
module tdq_queue_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  cfg_ctrl = '0;
   logic        op_wr = 1'b0;
   logic [1:0]  op_val = '0;
   logic [25:0] lvl_chk = '0;
   logic        push_en = 1'b0;
   logic [31:0] push_data = '0;
   logic        pop_en = 1'b0;
   logic [31:0] pop_data;
   logic [9:0]  status;
   logic        thr_hit;
   logic [2:0]  mark_hit;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   int          me;
   int          nb;
   int          cap;
   int          thr;
   int          mk [3];
   logic [31:0] q [256];
   int          head;
   int          tail;

   always #5 clk = ~clk;

   tdq_queue uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_ctrl  (cfg_ctrl),
      .op_wr     (op_wr),
      .op_val    (op_val),
      .lvl_chk   (lvl_chk),
      .push_en   (push_en),
      .push_data (push_data),
      .pop_en    (pop_en),
      .pop_data  (pop_data),
      .status    (status),
      .thr_hit   (thr_hit),
      .mark_hit  (mark_hit)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #2;
      push_en = 1'b0;
      pop_en  = 1'b0;
      op_wr   = 1'b0;
   endtask

   task automatic do_op(input logic [1:0] v);
      op_wr = 1'b1;
      op_val = v;
      cyc();
      if (v[0]) begin
         me = 0; head = 0; tail = 0;
      end
   endtask

   function automatic logic [31:0] msk(input logic [31:0] v);
      if (nb == 1) return v & 32'hFF;
      if (nb == 2) return v & 32'hFFFF;
      return v;
   endfunction

   task automatic chk_status(input string tag);
      logic [9:0] es;
      logic [2:0] em;
      es = {1'(me == 0), 1'(me == cap), 8'(me)};
      chk(status == es, {tag, " R3 status"}, 32'(status), 32'(es));
      chk(thr_hit == (me >= thr), {tag, " R10 threshold"}, 32'(thr_hit), 32'(me >= thr));
      for (int k = 0; k < 3; k++) em[k] = ((me * nb) / 4) >= mk[k];
      chk(mark_hit == em, {tag, " R11 marks"}, 32'(mark_hit), 32'(em));
   endtask

   task automatic push(input logic [31:0] v, input bit live);
      push_en = 1'b1;
      push_data = v;
      cyc();
      if (live && me < cap) begin
         q[tail] = msk(v); tail = (tail + 1) % 256; me++;
      end
   endtask

   task automatic pop_chk(input string tag, input bit live);
      if (me > 0)
         chk(pop_data == q[head], {tag, " R9 R1 data"}, pop_data, q[head]);
      pop_en = 1'b1;
      cyc();
      if (live && me > 0) begin
         head = (head + 1) % 256; me--;
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_fail++; n_tests++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      me = 0; head = 0; tail = 0; nb = 1; cap = 256; thr = 0;
      mk[0] = 10; mk[1] = 32; mk[2] = 63;
      lvl_chk = {6'd63, 4'd0, 6'd32, 4'd0, 6'd10};
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      cyc();
      chk(status == 10'h200, "R3 reset status", 32'(status), 32'h200);
      // R7: not started after reset, push ignored
      push(32'h11, 1'b0);
      chk(status == 10'h200, "R7 push before start", 32'(status), 32'h200);

      for (int w = 0; w < 4; w++) begin
         nb  = (w == 0) ? 1 : (w == 1) ? 2 : 4;
         cap = 256 / nb;
         thr = cap / 2;
         cfg_ctrl = {8'(thr), 2'(w)};
         do_op(2'b01);
         do_op(2'b10);
         chk_status("R6 after reset/start");
         // R2 R4: fill to capacity and one beyond
         for (int i = 0; i <= cap; i++) begin
            push((32'h9E3779B9 * (i + 1)) ^ (w << 28), 1'b1);
            chk_status(i == cap ? "R4 push when full" : "R2 fill");
         end
         chk(me == cap, "R2 capacity", me, cap);
         // R9 R5: drain and one beyond
         for (int i = 0; i <= cap; i++) begin
            pop_chk("R9 drain", 1'b1);
            chk_status(i == cap ? "R5 pop when empty" : "R9 drain level");
         end
      end

      // R1 byte order: word push, then read back as halfwords
      nb = 4; cap = 64; thr = 1;
      cfg_ctrl = {8'd1, 2'd2};
      do_op(2'b01); do_op(2'b10);
      push(32'hA1B2C3D4, 1'b1);
      cfg_ctrl = {8'd1, 2'd1};
      #1;
      chk(pop_data == 32'h0000C3D4, "R1 low half first", pop_data, 32'h0000C3D4);
      pop_en = 1'b1; cyc();
      chk(pop_data == 32'h0000A1B2, "R1 high half second", pop_data, 32'h0000A1B2);
      cfg_ctrl = {8'd1, 2'd0};
      #1;
      chk(pop_data == 32'h000000B2, "R1 byte zero-extend", pop_data, 32'h000000B2);

      // R12: simultaneous push and pop
      nb = 2; cap = 128; thr = 3;
      cfg_ctrl = {8'd3, 2'd1};
      do_op(2'b01); do_op(2'b10);
      push(32'h1111, 1'b1); push(32'h2222, 1'b1); push(32'h3333, 1'b1);
      chk(pop_data == 32'h1111, "R12 head before", pop_data, 32'h1111);
      push_en = 1'b1; push_data = 32'h4444; pop_en = 1'b1;
      cyc();
      q[tail] = 32'h4444; tail++; head++;
      chk_status("R12 level unchanged");
      chk(pop_data == 32'h2222, "R12 head advanced", pop_data, 32'h2222);

      // R7: stop keeps contents, ignores push and pop
      do_op(2'b00);
      push(32'h5555, 1'b0);
      pop_chk("R7 stopped", 1'b0);
      chk_status("R7 stopped level");
      chk(pop_data == 32'h2222, "R7 head kept", pop_data, 32'h2222);
      do_op(2'b10);
      pop_chk("R6 restart pop", 1'b1);
      chk_status("R6 restart level");

      // R8: reset and start together -> empty and stopped
      do_op(2'b11);
      chk_status("R8 emptied");
      push(32'h6666, 1'b0);
      chk_status("R8 stays stopped");
      // R6: op write cycle ignores a push
      op_wr = 1'b1; op_val = 2'b10; push_en = 1'b1; push_data = 32'h7777;
      cyc();
      chk_status("R6 push during op write ignored");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule